// File: doc/BRIEF.md
# Cascaded Master-Clock Prescaler

This block turns a fast external master clock into a slower internal master clock rate by passing it through three divider stages in series. It does not create a new clock: every stage runs on the one input clock and passes a one-cycle enable down the chain, so `imclk_en` is a clock-enable pulse train that logic downstream uses to advance at the internal rate. The overall ratio is the product of the three stage ratios, so ratios such as 6, 12 or 36 come out of small per-stage settings.

A second counter groups 256 internal-clock enables into one sample period and raises `sample_stb` once per period. With every stage passing through, a 12.288 MHz input yields one strobe per 256 input cycles, a 48 kHz sample rate; first stage at 3 and second at 2 gives a ratio of 6 and an 8 kHz rate. Ratio selections come from a control field, but the chain only adopts them on a sample boundary, so no internal clock period or sample period is ever cut short.

Top module: `mclk_prescale_chain`

## Requirements
- R1: `div1_sel` and `div2_sel` each choose the ratio of the first and second stage: code 00 divides by 1, 01 by 2, 10 by 3.
- R2: `div3_sel` chooses the ratio of the third stage: code 00 divides by 1, 01 by 2, 10 by 4.
- R3: The overall ratio N is the product of the three stage ratios; counting the input cycles of a sample period from 0, `imclk_en` is high for exactly one cycle in the cycle after each input cycle k with k mod N equal to N-1.
- R4: `sample_stb` is a single-cycle pulse that is high together with the 256th `imclk_en` pulse of every sample period, and at no other time.
- R5: While `rst` is high both outputs are low; after `rst` falls all stages divide by 1 whatever the select inputs hold, so `imclk_en` is high from the second clock edge after release and the first strobe follows 256 input cycles later.
- R6: The select inputs are sampled only at the clock edge that produces `sample_stb`; changes at any other time have no effect, and the new ratio N' starts with fresh stage counters, giving its first `imclk_en` pulse N' cycles after the strobe.
- R7: Select code 11 on any stage divides that stage by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External master clock |
| rst | input | 1 | Synchronous reset, active high |
| div1_sel | input | 2 | Ratio code for the first stage |
| div2_sel | input | 2 | Ratio code for the second stage |
| div3_sel | input | 2 | Ratio code for the third stage |
| imclk_en | output | 1 | Internal master clock enable, one cycle per internal clock |
| sample_stb | output | 1 | One-cycle strobe at the end of every sample period |

## Verification
On every cycle the assertions check that each stage counter stays below its ratio, that the active ratio set only moves on a sample boundary, that every strobe lands on exactly the 256th enable since the previous one, and that the enable train starts at once after reset. Only the bench's scenarios show the actual spacing of the enable pulses for each ratio combination, that code 11 behaves as pass-through, that the reset-time select values are ignored, and that mid-period select changes, including a transient value, are discarded in favour of the value present at the boundary.

// File: rtl/pscl_pkg.sv
package pscl_pkg;

  typedef logic [1:0] sel_t;

  // Ratio of one stage for a select code; quad picks the 1/2/4 set.
  function automatic logic [2:0] stage_ratio(sel_t s, logic quad);
    case (s)
      2'b01:   return 3'd2;
      2'b10:   return quad ? 3'd4 : 3'd3;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/pscl_stage.sv
module pscl_stage
  import pscl_pkg::*;
#(
  parameter bit QUAD = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  sel_t sel,
  input  logic en_in,
  output logic en_out
);

  localparam int MAXR = QUAD ? 4 : 3;
  localparam int CW   = $clog2(MAXR);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last   = CW'(stage_ratio(sel, QUAD) - 3'd1);
  assign en_out = en_in && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en_in) begin
      cnt <= (cnt == last) ? '0 : cnt + CW'(1);
    end
  end

  AST_CNT_BELOW_RATIO: assert property (@(posedge clk) disable iff (rst)
    cnt <= last); // R1 R2

endmodule

// File: rtl/pscl_frame.sv
module pscl_frame #(
  parameter int PERIOD = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic wrap
);

  localparam int FW = $clog2(PERIOD);

  logic [FW-1:0] cnt;

  assign wrap = tick && (cnt == FW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= wrap ? '0 : cnt + FW'(1);
    end
  end

endmodule

// File: rtl/mclk_prescale_chain.sv
module mclk_prescale_chain
  import pscl_pkg::*;
#(
  parameter int SAMPLE_DIV = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] div1_sel,
  input  logic [1:0] div2_sel,
  input  logic [1:0] div3_sel,
  output logic       imclk_en,
  output logic       sample_stb
);

  localparam int              NSTG      = 3;
  localparam logic [NSTG-1:0] QUAD_MASK = 3'b100;
  localparam int              SW        = $clog2(SAMPLE_DIV) + 1;

  logic [NSTG-1:0][1:0] cfg_sel;
  logic [NSTG-1:0][1:0] act_sel;
  logic [NSTG:0]        en_chain;
  logic                 frame_wrap;

  assign cfg_sel[0]  = div1_sel;
  assign cfg_sel[1]  = div2_sel;
  assign cfg_sel[2]  = div3_sel;
  assign en_chain[0] = 1'b1;

  // Active ratios: pass-through after reset, reloaded only at a boundary.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_sel <= '0;
    end else if (frame_wrap) begin
      act_sel <= cfg_sel;
    end
  end

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    pscl_stage #(
      .QUAD (QUAD_MASK[g])
    ) u_stage (
      .clk    (clk),
      .rst    (rst),
      .clr    (frame_wrap),
      .sel    (act_sel[g]),
      .en_in  (en_chain[g]),
      .en_out (en_chain[g+1])
    );
  end

  pscl_frame #(
    .PERIOD (SAMPLE_DIV)
  ) u_frame (
    .clk  (clk),
    .rst  (rst),
    .tick (en_chain[NSTG]),
    .wrap (frame_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      imclk_en   <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      imclk_en   <= en_chain[NSTG];
      sample_stb <= frame_wrap;
    end
  end

  // Independent count of output enables since the last strobe.
  logic [SW-1:0] en_seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      en_seen <= '0;
    end else if (imclk_en) begin
      en_seen <= sample_stb ? '0 : en_seen + SW'(1);
    end
  end

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_wrap |=> $stable(act_sel)); // R6
  AST_STB_ON_LAST_EN: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> (imclk_en && en_seen == SW'(SAMPLE_DIV - 1))); // R4
  AST_NO_MISSED_STB: assert property (@(posedge clk) disable iff (rst)
    en_seen < SW'(SAMPLE_DIV)); // R4
  AST_START_PASS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> imclk_en); // R5

endmodule

// File: tb/mclk_prescale_chain_bench.sv
module mclk_prescale_chain_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] div1_sel, div2_sel, div3_sel;
  logic       imclk_en, sample_stb;

  int n_chk = 0;
  int n_bad = 0;
  bit mon_go = 0;
  bit done   = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  mclk_prescale_chain u_mclk_prescale_chain (
    .clk        (clk),
    .rst        (rst),
    .div1_sel   (div1_sel),
    .div2_sel   (div2_sel),
    .div3_sel   (div3_sel),
    .imclk_en   (imclk_en),
    .sample_stb (sample_stb)
  );

  function automatic int ratio_of(logic [1:0] s, bit quad);
    case (s)
      2'b01:   return 2;
      2'b10:   return quad ? 4 : 3;
      default: return 1;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Driver side: expected enable/strobe pattern of one sample period.
  task automatic push_period(int n, string tag);
    for (int i = 0; i < 256 * n; i++) begin
      exp_q.push_back({(i % n) == n - 1, i == 256 * n - 1});
      tag_q.push_back(tag);
    end
  endtask

  // Monitor: pops one expected item per cycle.
  initial begin
    wait (mon_go);
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(imclk_en == e[1], t, imclk_en, e[1]);
        check(sample_stb == e[0], "R4", sample_stb, e[0]);
      end
    end
  end

  initial begin
    logic [5:0] cfg [7];
    string      tg  [7];
    int         rat [7];
    // per period: select applied during it (for the next period), tag of the period
    cfg[0] = {2'b10, 2'b01, 2'b00}; tg[0] = "R5";  // pass-through after reset
    cfg[1] = {2'b00, 2'b00, 2'b10}; tg[1] = "R1";  // ratio 6 = 3*2*1
    cfg[2] = {2'b10, 2'b10, 2'b10}; tg[2] = "R2";  // ratio 4 from stage 3
    cfg[3] = {2'b11, 2'b11, 2'b11}; tg[3] = "R3";  // ratio 36
    cfg[4] = {2'b01, 2'b10, 2'b01}; tg[4] = "R7";  // code 11 everywhere -> 1
    cfg[5] = {2'b01, 2'b00, 2'b00}; tg[5] = "R6";  // ratio 12 after transient
    cfg[6] = {2'b00, 2'b00, 2'b00}; tg[6] = "R3";  // ratio 2
    rat[0] = 1;
    for (int p = 1; p < 7; p++)
      rat[p] = ratio_of(cfg[p-1][5:4], 0) * ratio_of(cfg[p-1][3:2], 0) *
               ratio_of(cfg[p-1][1:0], 1);

    {div1_sel, div2_sel, div3_sel} = cfg[0];
    repeat (3) @(negedge clk);
    check(imclk_en == 1'b0, "R5", imclk_en, 0);
    check(sample_stb == 1'b0, "R5", sample_stb, 0);
    rst = 1'b0;
    mon_go = 1;
    for (int p = 0; p < 7; p++) begin
      push_period(rat[p], tg[p]);
      repeat (20) @(negedge clk);
      {div1_sel, div2_sel, div3_sel} = ~cfg[(p + 1) % 7]; // transient, R6
      repeat (20) @(negedge clk);
      {div1_sel, div2_sel, div3_sel} = (p < 6) ? cfg[p] : 6'd0;
      wait (exp_q.size() == 0);
    end
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule